// File: doc/BRIEF.md
# Sequential Signed Multiplier

This block multiplies two signed operands of WIDTH bits each and returns the full signed product of 2*WIDTH bits. It works one multiplier bit per clock. A pulse on `start` while the unit is idle captures both operands. `busy` is then high for exactly WIDTH cycles. The result appears on `product` together with a one-cycle `done` pulse, and it stays there until the next operation is accepted.

The product lives in two WIDTH-bit registers. The upper half holds the running partial sum. The lower half first holds the multiplier. On each step the multiplier bit at the bottom of the lower half decides whether the multiplicand joins the upper half through an adder that is one bit wider than an operand. The pair then shifts right by one bit: the top copies the sign and the finished low bit drops into the lower half. The top multiplier bit carries negative weight, so on the final step the multiplicand is subtracted instead of added. A negative multiplicand needs nothing beyond the sign-copying shift.

Top module: `seq_signed_mult`

## Requirements
- R1: When `done` is high, `product` equals the signed product of the operands captured at the accepted start, as a two's complement value of 2*WIDTH bits.
- R2: After an accepted start, `busy` is high for exactly WIDTH consecutive cycles, beginning the cycle after `start` was sampled.
- R3: `done` is high for exactly one cycle, in the cycle right after `busy` falls, and is never high together with `busy`.
- R4: A `start` that arrives while `busy` is high is ignored. It changes neither the timing nor the result of the running operation.
- R5: Operands are captured only in the cycle `start` is accepted. Later changes on the operand inputs do not affect the result.
- R6: A negative multiplier, including the most negative value, gives the correct product. This works because the last step subtracts the multiplicand.
- R7: The extreme operand pairs (most negative by most negative, most negative by most positive, most positive by most positive) give exact products. For example, -2^(WIDTH-1) squared is 2^(2*WIDTH-2).
- R8: While reset is held and after it is released, `busy` and `done` are 0 and `product` is 0 until the first start is accepted.
- R9: While idle and with no start accepted, `product` holds its last value.
- R10: A `start` in the same cycle as `done` is accepted and begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request a new multiplication; accepted only when not busy |
| multiplicand | input | WIDTH | Signed multiplicand, sampled on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | High during the WIDTH iteration cycles |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. This happens when `start` is driven during the cycle that `done` is high. The bench provokes this case directly. It reads the finished product in that cycle, then checks that `busy` rises on the next cycle with `done` cleared, and that the second result is exact. A second overlap, a start raised in the middle of a run with different operands, is judged by the unchanged busy length and the first operation's product.

// File: rtl/mult_pkg.sv
package mult_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_FIN  = 2'd2
  } mult_state_e;

endpackage

// File: rtl/mult_rst_sync.sv
module mult_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  mult_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  // accept only outside the iteration phase
  assign load = start && (state_q != MS_RUN);
  assign step = (state_q == MS_RUN);
  assign last = step && (cnt_q == LAST_IDX);
  assign busy = (state_q == MS_RUN);
  assign done = (state_q == MS_FIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      MS_IDLE: if (load) state_d = MS_RUN;
      MS_RUN:  if (last) state_d = MS_FIN;
      MS_FIN:  state_d = load ? MS_RUN : MS_IDLE;
      default: state_d = MS_IDLE;
    endcase
  end

  assign cnt_en = load || step;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mult_addsub.sv
module mult_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] operand,
  input  logic             en,
  input  logic             sub,
  output logic [WIDTH:0]   res
);

  logic [WIDTH:0] acc_ext;
  logic [WIDTH:0] op_ext;
  logic [WIDTH:0] op_sel;

  // one guard bit keeps the sum exact for any pair of signed inputs
  assign acc_ext = {acc[WIDTH-1], acc};
  assign op_ext  = {operand[WIDTH-1], operand};
  assign op_sel  = sub ? ~op_ext : op_ext;

  always_comb begin
    if (en) begin
      res = acc_ext + op_sel + {{WIDTH{1'b0}}, sub};
    end else begin
      res = acc_ext;
    end
  end

endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               last,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [WIDTH-1:0] hi_q, hi_d;
  logic [WIDTH-1:0] lo_q, lo_d;
  logic [WIDTH:0]   sum;
  logic             reg_en;

  mult_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc     (hi_q),
    .operand (mcand_q),
    .en      (lo_q[0]),
    .sub     (last),
    .res     (sum)
  );

  assign reg_en = load || step;

  always_comb begin
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (load) begin
      mcand_d = mcand_in;
      hi_d    = '0;
      lo_d    = mplier_in;
    end else if (step) begin
      // sign-preserving shift of the guard-extended sum
      hi_d = sum[WIDTH:1];
      lo_d = {sum[0], lo_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (reg_en) begin
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign product = {hi_q, lo_q};

endmodule

// File: rtl/seq_signed_mult.sv
module seq_signed_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  logic rst_sync_n;
  logic load;
  logic step;
  logic last;

  mult_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .step      (step),
    .last      (last),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .product   (product)
  );

endmodule

// File: rtl/mult_checker.sv
module mult_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int CW = 32;

  logic [WIDTH-1:0]   mc_q;
  logic [WIDTH-1:0]   mp_q;
  logic [CW-1:0]      busy_cnt_q;
  logic [2*WIDTH-1:0] ref_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
      mp_q <= '0;
    end else if (start && !busy) begin
      mc_q <= multiplicand;
      mp_q <= multiplier;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
    end else begin
      busy_cnt_q <= busy ? busy_cnt_q + 1 : '0;
    end
  end

  assign ref_prod = $signed({{WIDTH{mc_q[WIDTH-1]}}, mc_q}) *
                    $signed({{WIDTH{mp_q[WIDTH-1]}}, mp_q});

  // R1 R6 R7
  p_product_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_prod));

  // R2
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2 R4
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt_q == CW'(WIDTH)));

  // R3
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  p_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

bind seq_signed_mult mult_checker #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/test_seq_signed_mult.sv
`timescale 1ns/1ps
module test_seq_signed_mult;

  logic clk;
  logic rst_n;

  logic        st8, busy8, done8;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic        st4, busy4, done4;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;

  int n_cmp;
  int n_bad;
  bit finished;

  seq_signed_mult #(.WIDTH(8)) i_seq_signed_mult (
    .clk(clk), .rst_n(rst_n), .start(st8), .multiplicand(a8),
    .multiplier(b8), .busy(busy8), .done(done8), .product(p8));

  seq_signed_mult #(.WIDTH(4)) i_seq_signed_mult_w4 (
    .clk(clk), .rst_n(rst_n), .start(st4), .multiplicand(a4),
    .multiplier(b4), .busy(busy4), .done(done4), .product(p4));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // operand pairs {multiplicand, multiplier}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'h0305, 16'hFD05, 16'h05FD, 16'hFDFB, 16'h0000, 16'h7F00,
    16'h0180, 16'h8001, 16'hFFFF, 16'h80FF, 16'h4B39, 16'hC3A7
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input string tag, input bit now);
    logic signed [7:0]  sa;
    logic signed [7:0]  sb;
    logic signed [15:0] e;
    int bc;
    sa = a; sb = b; e = sa * sb;
    if (!now) @(negedge clk);
    st8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk);
    st8 = 1'b0;
    bc = 0;
    for (int k = 0; k < 8; k++) begin
      if (busy8) bc++;
      @(negedge clk);
    end
    chk(bc == 8, "R2 busy cycles", bc, 8);
    chk(done8 && !busy8, "R3 done pulse", {busy8, done8}, 2'b01);
    chk(p8 == e, tag, p8, e);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b);
    logic signed [3:0] sa;
    logic signed [3:0] sb;
    logic signed [7:0] e;
    sa = a; sb = b; e = sa * sb;
    @(negedge clk);
    st4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk);
    st4 = 1'b0;
    repeat (4) @(negedge clk);
    chk(p4 == e && done4, "R1 width4", {done4, p4}, {1'b1, e});
  endtask

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0;
    st8 = 1'b0; a8 = '0; b8 = '0;
    st4 = 1'b0; a4 = '0; b4 = '0;
    repeat (3) @(negedge clk);
    // R8 during reset
    chk(!busy8 && !done8 && p8 == 0, "R8 in reset", {busy8, done8, p8}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy8 && !done8 && p8 == 0, "R8 after release", {busy8, done8, p8}, 0);
    chk(!busy4 && !done4 && p4 == 0, "R8 width4", {busy4, done4, p4}, 0);

    for (int i = 0; i < NV; i++) run8(VEC[i][15:8], VEC[i][7:0], "R1 table", 1'b0);

    // R6 negative multipliers, including the most negative
    run8(8'd5, 8'h80, "R6 neg multiplier", 1'b0);
    run8(8'hF9, 8'h80, "R6 neg both", 1'b0);
    // R7 extremes
    run8(8'h80, 8'h80, "R7 min*min", 1'b0);
    run8(8'h80, 8'h7F, "R7 min*max", 1'b0);
    run8(8'h7F, 8'h80, "R7 max*min", 1'b0);
    run8(8'h7F, 8'h7F, "R7 max*max", 1'b0);

    for (int i = 0; i < 40; i++) run8(8'($urandom), 8'($urandom), "R1 random", 1'b0);

    // R10 start in the done cycle, back to back
    run8(8'd9, 8'hF7, "R10 first", 1'b0);
    run8(8'hEE, 8'd3, "R10 chained", 1'b1);

    // R9 hold while idle
    held = p8;
    repeat (6) @(negedge clk);
    chk(p8 == held && !done8 && !busy8, "R9 hold", p8, held);

    // R4 and R5: start pulse and operand change during a run
    begin
      int bc;
      @(negedge clk);
      st8 = 1'b1; a8 = 8'd5; b8 = 8'hFD;
      @(negedge clk);
      st8 = 1'b0; a8 = 8'h64; b8 = 8'h64;   // R5 inputs change after capture
      bc = 0;
      for (int k = 0; k < 8; k++) begin
        if (busy8) bc++;
        st8 = (k == 2);                      // R4 start while busy
        @(negedge clk);
      end
      st8 = 1'b0;
      chk(bc == 8, "R4 busy length", bc, 8);
      chk(done8, "R4 done timing", done8, 1);
      chk(p8 == 16'hFFF1, "R5 captured operands", p8, 16'hFFF1);
      @(negedge clk);
      chk(!busy8 && !done8 && p8 == 16'hFFF1, "R4 no restart", {busy8, done8, p8}, 17'h0FFF1);
    end

    // exhaustive at width 4
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run4(4'(x), 4'(y));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule